// File: doc/BRIEF.md
# Segment-Configurable Address Translator

This block turns a 32-bit virtual address into one of three outcomes: an address error, a request for a TLB lookup (mapped), or a direct physical address (unmapped). It does this for the current privilege context. Each address segment carries its own 16-bit configuration taken from one of three 32-bit segment-control inputs. The configuration's 3-bit access mode decides, per privilege context, whether the segment faults, goes through the TLB, or bypasses it.

For an unmapped segment the block builds a 36-bit physical address. It places the segment's 7-bit base field at bits 35:29 and clears the bits covered by the segment's offset mask. It then fills those masked bits from the virtual address. A mapped result only raises the `mapped` flag, and the TLB itself sits outside the block. With `REG_OUT` set (the default), all outputs pass through one register stage.

Top module: `seg_xlate`

## Requirements
- R1: Segment selection is made on the virtual address.
  - Addresses below 0x40000000 use `segctl2[31:16]`, with offset mask 0x3FFFFFFF.
  - Addresses from 0x40000000 to 0x7FFFFFFF use `segctl2[15:0]`, with mask 0x3FFFFFFF.
  - Addresses 0x80000000 to 0x9FFFFFFF use `segctl1[31:16]`.
  - Addresses 0xA0000000 to 0xBFFFFFFF use `segctl1[15:0]`.
  - Addresses 0xC0000000 to 0xDFFFFFFF use `segctl0[31:16]`.
  - Addresses 0xE0000000 and above use `segctl0[15:0]`.
  - The last four regions use offset mask 0x1FFFFFFF.
  - The halves that are not selected have no effect.
- R2: Kernel context (`priv`=0): no access mode gives an error. Access modes 1, 2 and 3 are mapped, and modes 0, 4, 5, 6 and 7 are unmapped.
- R3: Supervisor context (`priv`=1): access modes 0 and 1 give `ade`. Modes 2, 3 and 4 are mapped, and modes 5, 6 and 7 are unmapped.
- R4: User context (`priv`=2): access modes 0, 1, 2 and 5 give `ade`. Modes 3 and 4 are mapped, and modes 6 and 7 are unmapped.
- R5: Error-level context (`priv`=3): when the selected configuration's EU bit (bit 3) is set, the result is always unmapped. When EU is clear, the result follows the kernel rules of R2.
- R6: When the result is unmapped, `paddr` is ({PA, 29'b0} with the masked bits cleared) OR (`vaddr` AND mask). PA is bits 15:9 of the selected configuration, and the access mode (AM) is bits 6:4.
- R7: `paddr` is zero whenever `unmapped_hit` is low. Configuration bits 8:7 and 2:0 have no effect on any output.
- R8: Outside reset, exactly one of `ade`, `mapped`, `unmapped_hit` is high.
- R9: With `REG_OUT`=1, outputs reflect the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| vaddr | input | 32 | Virtual address |
| priv | input | 2 | Privilege context: 0 kernel, 1 supervisor, 2 user, 3 error-level |
| segctl0 | input | 32 | Configurations for 0xC0000000 (high half) and 0xE0000000 (low half) |
| segctl1 | input | 32 | Configurations for 0x80000000 (high half) and 0xA0000000 (low half) |
| segctl2 | input | 32 | Configurations for the user region: lower half-region (high half) and upper half-region (low half) |
| ade | output | 1 | Address error |
| mapped | output | 1 | TLB lookup required |
| unmapped_hit | output | 1 | Direct translation valid in `paddr` |
| paddr | output | 36 | Physical address for an unmapped result, otherwise zero |

## Verification
Every flag and `paddr` is due one clock after its inputs are applied, because the default build registers the outputs. The bench changes inputs on a falling edge. It reads the results on the next falling edge, after exactly one rising edge. One nanosecond after each new input it also confirms that the outputs still hold the previous result, which pins the single-cycle latency. During reset it expects all outputs at zero.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter bit REG_OUT = 1'b1,
  parameter int PA_FIELD_W = 7,
  parameter int CFG_PA_LSB = 9,
  parameter int PA_SHIFT = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] vaddr,
  input  logic [1:0]  priv,
  input  logic [31:0] segctl0,
  input  logic [31:0] segctl1,
  input  logic [31:0] segctl2,
  output logic        ade,
  output logic        mapped,
  output logic        unmapped_hit,
  output logic [CFG_PA_LSB+PA_FIELD_W+PA_SHIFT-1:0] paddr
);
  localparam int PA_W = CFG_PA_LSB + PA_FIELD_W + PA_SHIFT;
  localparam int BASE_LSB = CFG_PA_LSB + PA_SHIFT;

  logic [15:0] cfg;
  logic [31:0] omask;

  always_comb begin
    omask = 32'h1FFF_FFFF;
    unique case (vaddr[31:29])
      3'b000, 3'b001: begin cfg = segctl2[31:16]; omask = 32'h3FFF_FFFF; end
      3'b010, 3'b011: begin cfg = segctl2[15:0];  omask = 32'h3FFF_FFFF; end
      3'b100:         cfg = segctl1[31:16];
      3'b101:         cfg = segctl1[15:0];
      3'b110:         cfg = segctl0[31:16];
      default:        cfg = segctl0[15:0];
    endcase
  end

  logic [2:0] am_s;
  logic       eu_s;
  logic [PA_FIELD_W-1:0] pa_s;
  logic       unused_cfg;
  assign am_s = cfg[6:4];
  assign eu_s = cfg[3];
  assign pa_s = cfg[CFG_PA_LSB +: PA_FIELD_W];
  assign unused_cfg = ^{cfg[8:7], cfg[2:0]};

  logic c_ade, c_map, c_unm;
  logic kmap;
  assign kmap = (am_s == 3'd1) || (am_s == 3'd2) || (am_s == 3'd3);

  always_comb begin
    c_ade = 1'b0;
    c_map = 1'b0;
    unique case (priv)
      2'd0: c_map = kmap;
      2'd1: begin
        c_ade = (am_s == 3'd0) || (am_s == 3'd1);
        c_map = (am_s == 3'd2) || (am_s == 3'd3) || (am_s == 3'd4);
      end
      2'd2: begin
        c_ade = (am_s <= 3'd2) || (am_s == 3'd5);
        c_map = (am_s == 3'd3) || (am_s == 3'd4);
      end
      default: c_map = !eu_s && kmap;
    endcase
  end
  assign c_unm = !c_ade && !c_map;

  logic [PA_W-1:0] wmask, base, c_paddr;
  assign wmask = PA_W'(omask);
  assign base = {pa_s, {BASE_LSB{1'b0}}};
  assign c_paddr = c_unm ? ((base & ~wmask) | (PA_W'(vaddr) & wmask)) : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ade <= 1'b0;
          mapped <= 1'b0;
          unmapped_hit <= 1'b0;
          paddr <= '0;
        end else begin
          ade <= c_ade;
          mapped <= c_map;
          unmapped_hit <= c_unm;
          paddr <= c_paddr;
        end
      end
    end else begin : g_comb
      assign ade = c_ade;
      assign mapped = c_map;
      assign unmapped_hit = c_unm;
      assign paddr = c_paddr;
    end
  endgenerate
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter bit REG_OUT = 1'b1,
  parameter int PA_W = 36
) (
  input logic clk,
  input logic rst_n,
  input logic [1:0] priv,
  input logic [2:0] am_s,
  input logic eu_s,
  input logic c_ade,
  input logic c_map,
  input logic c_unm,
  input logic ade,
  input logic mapped,
  input logic unmapped_hit,
  input logic [PA_W-1:0] paddr
);
  p_kernel_no_ade_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd0) |-> !c_ade);

  p_sup_low_am_ade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd1 && am_s <= 3'd1) |-> (c_ade && !c_map));

  p_user_high_am_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd2 && am_s >= 3'd6) |-> c_unm);

  p_eu_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd3 && eu_s) |-> c_unm);

  p_paddr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unmapped_hit |-> (paddr == '0));

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({c_ade, c_map, c_unm}) == 1);

  generate
    if (REG_OUT) begin : g_lat
      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ade == $past(c_ade) && mapped == $past(c_map)
                          && unmapped_hit == $past(c_unm)));
    end
  endgenerate
endmodule

bind seg_xlate seg_xlate_chk #(.REG_OUT(REG_OUT), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .am_s(am_s), .eu_s(eu_s),
  .c_ade(c_ade), .c_map(c_map), .c_unm(c_unm),
  .ade(ade), .mapped(mapped), .unmapped_hit(unmapped_hit), .paddr(paddr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0] priv = '0;
  logic [31:0] segctl0 = '0, segctl1 = '0, segctl2 = '0;
  logic ade, mapped, unmapped_hit;
  logic [35:0] paddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .priv(priv),
    .segctl0(segctl0), .segctl1(segctl1), .segctl2(segctl2),
    .ade(ade), .mapped(mapped), .unmapped_hit(unmapped_hit), .paddr(paddr)
  );

  // outcome class: 0 unmapped, 1 mapped, 2 address error
  function automatic logic [1:0] cls(input logic [1:0] m, input logic [2:0] a, input logic e);
    logic km;
    km = (a >= 3'd1 && a <= 3'd3);
    case (m)
      2'd0: cls = km ? 2'd1 : 2'd0;
      2'd1: cls = (a <= 3'd1) ? 2'd2 : ((a >= 3'd2 && a <= 3'd4) ? 2'd1 : 2'd0);
      2'd2: cls = (a <= 3'd2 || a == 3'd5) ? 2'd2 : ((a == 3'd3 || a == 3'd4) ? 2'd1 : 2'd0);
      default: cls = e ? 2'd0 : (km ? 2'd1 : 2'd0);
    endcase
  endfunction

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'd0: mtag = "R2";
      2'd1: mtag = "R3";
      2'd2: mtag = "R4";
      default: mtag = "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [2:0]  prev_flags;
  logic [35:0] prev_pa;
  logic        have_prev = 1'b0;

  task automatic run_vec(input logic [1:0] m, input logic [2:0] a, input logic e,
                         input int s, input logic [6:0] pa, input logic [31:0] off,
                         input logic [4:0] junk);
    logic [15:0] cf, other;
    logic [31:0] va, msk;
    logic [1:0]  c;
    logic [2:0]  ef;
    logic [35:0] ep, wm;
    cf = {pa, junk[4:3], a, e, junk[2:0]};
    other = ~cf;
    @(negedge clk);
    segctl0 = {other, other};
    segctl1 = {other, other};
    segctl2 = {other, other};
    msk = 32'h1FFF_FFFF;
    case (s)
      0: begin va = off & 32'h3FFF_FFFF; segctl2[31:16] = cf; msk = 32'h3FFF_FFFF; end
      1: begin va = (off & 32'h3FFF_FFFF) | 32'h4000_0000; segctl2[15:0] = cf; msk = 32'h3FFF_FFFF; end
      2: begin va = {3'b100, off[28:0]}; segctl1[31:16] = cf; end
      3: begin va = {3'b101, off[28:0]}; segctl1[15:0] = cf; end
      4: begin va = {3'b110, off[28:0]}; segctl0[31:16] = cf; end
      default: begin va = {3'b111, off[28:0]}; segctl0[15:0] = cf; end
    endcase
    vaddr = va;
    priv = m;
    #1;
    if (have_prev) begin
      check("R9 hold before edge", {25'b0, ade, mapped, unmapped_hit, paddr}, {25'b0, prev_flags, prev_pa});
    end
    c = cls(m, a, e);
    ef = (c == 2'd2) ? 3'b100 : ((c == 2'd1) ? 3'b010 : 3'b001);
    wm = {4'b0, msk};
    ep = (c == 2'd0) ? (({pa, 29'b0} & ~wm) | ({4'b0, va} & wm)) : 36'b0;
    @(negedge clk);
    check($sformatf("R1 %s flags m=%0d am=%0d eu=%0d seg=%0d", mtag(m), m, a, e, s),
          {61'b0, ade, mapped, unmapped_hit}, {61'b0, ef});
    check($sformatf("%s paddr m=%0d am=%0d seg=%0d", (c == 2'd0) ? "R6" : "R7", m, a, s),
          {28'b0, paddr}, {28'b0, ep});
    check("R8 one flag", 64'($countones({ade, mapped, unmapped_hit})), 64'd1);
    prev_flags = {ade, mapped, unmapped_hit};
    prev_pa = paddr;
    have_prev = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] off;
    int n;
    vaddr = 32'h8000_0000;
    segctl1 = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 reset outputs zero", {25'b0, ade, mapped, unmapped_hit, paddr}, 64'b0);
    rst_n = 1'b1;
    n = 0;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++)
        for (int e = 0; e < 2; e++)
          for (int s = 0; s < 6; s++) begin
            off = 32'h1234_5678 ^ (32'(n) * 32'h9E37_79B9);
            run_vec(2'(m), 3'(a), e[0], s, 7'(n * 37 + 11), off, 5'(n * 13));
            n++;
          end
    run_vec(2'd0, 3'd0, 1'b0, 2, 7'h7F, 32'hFFFF_FFFF, 5'h1F);
    run_vec(2'd0, 3'd0, 1'b0, 0, 7'h7F, 32'hFFFF_FFFF, 5'h00);
    run_vec(2'd3, 3'd2, 1'b1, 5, 7'h00, 32'h0000_0000, 5'h15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule